// File: doc/BRIEF.md
# Three-wire serial word receiver

This block takes tuner settings from a host over a three-line serial link: a serial clock, a data line and an enable line. While enable is high, each falling edge of the serial clock shifts one data bit into an 18-bit register. When enable falls, the register is copied into the output latches, but only if exactly eighteen falling clock edges arrived during that high period. Any other count, including a very long burst, leaves the previous outputs in place.

The committed word supplies a 15-bit divider value and three port bits. The top divider bit is always zero, so only 14 bits carry the scaling factor. A committed scaling factor of zero raises a flag that turns the whole loop off.

The block also drives fixed control levels for this link mode. It turns a 2-bit reference-select code, already decoded from the select pin, into a reference division ratio. All link inputs are sampled on the system clock `clk`. Each link level must therefore last at least two system clocks.

Top module: `tri_wire_rx`

## Requirements
- R1: After reset the divider word is 0, the port bits are 3'b000 and the loop-off flag is 1.
- R2: On each falling edge of `ser_clk` while `ser_en` is high, one bit of `ser_data` is shifted in. The word is sent MSB first, in this order: P0, P1, P2, one unused bit, then scaling-factor bits 13 down to 0. P0 lands in `port_bits[0]`, P1 in `port_bits[1]` and P2 in `port_bits[2]`.
- R3: When `ser_en` falls after exactly 18 shift edges, the word loads into the output latches. After 17, 19 or any other count, the outputs keep their previous values.
- R4: Falling edges of `ser_clk` while `ser_en` is low are ignored. They do not add to the count of the next enable period.
- R5: The edge count saturates at 31. A burst of 50 edges is therefore rejected and does not wrap around to a valid count.
- R6: `div_word[14]` is always 0, and `div_word[13:0]` holds the received scaling factor.
- R7: The control outputs are fixed: `cp_high`=1, `div_test`=0, `cp_off`=0, `presc_on`=1, `drive_off`=0.
- R8: `ref_ratio` decodes `ref_sel` combinationally: 2'b00 (low band) gives 1024, 2'b10 (high band) gives 640, and 2'b01 (mid band or open) or 2'b11 gives 512.
- R9: `pll_off` is 1 exactly when the latched scaling factor is zero.
- R10: The latched outputs change only in the system-clock cycle that follows a valid commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Serial link clock |
| ser_data | input | 1 | Serial link data |
| ser_en | input | 1 | Serial link enable |
| ref_sel | input | 2 | Pre-decoded reference-select code |
| div_word | output | 15 | Latched divider word |
| port_bits | output | 3 | Latched port bits |
| pll_off | output | 1 | High when the latched scaling factor is zero |
| ref_ratio | output | 11 | Reference division ratio |
| cp_high | output | 1 | Charge-pump high-current select (fixed 1) |
| div_test | output | 1 | Divider test mode (fixed 0) |
| cp_off | output | 1 | Charge-pump disable (fixed 0) |
| presc_on | output | 1 | Prescaler enable (fixed 1) |
| drive_off | output | 1 | Tuning-drive disable (fixed 0) |

## Verification
The link is driven with several kinds of burst:
- Well-formed 18-edge words carrying different port and scaling-factor patterns. These show that the bit order and field placement are correct.
- Bursts of 17, 19 and 50 edges. These separate an exact-count check from a minimum-count check, and show that a saturating counter differs from one that wraps.
- Serial clock edges sent with enable low just before a valid word. These show whether idle edges leak into the count of the next period.
- A zero scaling factor followed by an all-ones factor, and a sweep of all four select codes. These cover the loop-off flag and the ratio decode.

// File: rtl/tri_wire_rx.sv
module tri_wire_rx #(
  parameter int WORD_LEN = 18,
  parameter int SF_W     = 14,
  parameter int PORT_W   = 3,
  parameter int CNT_W    = 5,
  parameter int DIV_W    = 15,
  parameter int RATIO_W  = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               ser_en,
  input  logic [1:0]         ref_sel,
  output logic [DIV_W-1:0]   div_word,
  output logic [PORT_W-1:0]  port_bits,
  output logic               pll_off,
  output logic [RATIO_W-1:0] ref_ratio,
  output logic               cp_high,
  output logic               div_test,
  output logic               cp_off,
  output logic               presc_on,
  output logic               drive_off
);
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam int PAD_W   = DIV_W - SF_W;

  logic                clk_r, clk_d, en_r, en_d, dat_r;
  logic [WORD_LEN-1:0] sr;
  logic [CNT_W-1:0]    cnt;
  logic                shift, commit;

  assign shift  = clk_d & ~clk_r & en_r;
  assign commit = en_d & ~en_r & (cnt == CNT_W'(WORD_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_r <= 1'b0;
      clk_d <= 1'b0;
      en_r  <= 1'b0;
      en_d  <= 1'b0;
      dat_r <= 1'b0;
    end else begin
      clk_r <= ser_clk;
      clk_d <= clk_r;
      en_r  <= ser_en;
      en_d  <= en_r;
      dat_r <= ser_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else begin
      if (shift) sr <= {sr[WORD_LEN-2:0], dat_r};
      if (!en_r) cnt <= '0;
      else if (shift && cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_word  <= '0;
      port_bits <= '0;
    end else if (commit) begin
      div_word <= {{PAD_W{1'b0}}, sr[SF_W-1:0]};
      for (int i = 0; i < PORT_W; i++) port_bits[i] <= sr[WORD_LEN-1-i];
    end
  end

  assign pll_off = (div_word == '0);

  always_comb begin
    case (ref_sel)
      2'b00:   ref_ratio = RATIO_W'(1024);
      2'b10:   ref_ratio = RATIO_W'(640);
      default: ref_ratio = RATIO_W'(512);
    endcase
  end

  assign cp_high   = 1'b1;
  assign div_test  = 1'b0;
  assign cp_off    = 1'b0;
  assign presc_on  = 1'b1;
  assign drive_off = 1'b0;

  // R10
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(div_word) && $stable(port_bits)));

  // R2
  load_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (div_word[SF_W-1:0] == $past(sr[SF_W-1:0])));

  // R5
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_r && cnt == CNT_W'(CNT_MAX)) |=> (cnt == CNT_W'(CNT_MAX)));

  // R4
  idle_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_r |=> $stable(sr));
endmodule

// File: tb/tb_tri_wire_rx.sv
module tb_tri_wire_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_en = 1'b0;
  logic [1:0] ref_sel = 2'b01;
  logic [14:0] div_word;
  logic [2:0] port_bits;
  logic pll_off, cp_high, div_test, cp_off, presc_on, drive_off;
  logic [10:0] ref_ratio;

  int total = 0, bad = 0;
  bit settle = 1'b1;
  bit q[$];
  logic [13:0] exp_sf = '0;
  logic [2:0]  exp_port = '0;

  tri_wire_rx dut (.*);

  always #5 clk = ~clk;

  function automatic int ratio_of(logic [1:0] s);
    if (s == 2'b00) return 1024;
    if (s == 2'b10) return 640;
    return 512;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !settle) begin
      total++;
      if (div_word !== {1'b0, exp_sf}) begin
        bad++; $display("FAIL R3/R6 div_word act=%h exp=%h", div_word, {1'b0, exp_sf});
      end else if (port_bits !== exp_port) begin
        bad++; $display("FAIL R2 port_bits act=%b exp=%b", port_bits, exp_port);
      end else if (pll_off !== (exp_sf == 0)) begin
        bad++; $display("FAIL R9 pll_off act=%b exp=%b", pll_off, exp_sf == 0);
      end else if (int'(ref_ratio) != ratio_of(ref_sel)) begin
        bad++; $display("FAIL R8 ref_ratio act=%0d exp=%0d", ref_ratio, ratio_of(ref_sel));
      end else if ({cp_high, div_test, cp_off, presc_on, drive_off} !== 5'b10010) begin
        bad++; $display("FAIL R7 controls act=%b exp=10010",
                        {cp_high, div_test, cp_off, presc_on, drive_off});
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(bit d, bit record);
    ser_data = d;
    tick(2);
    ser_clk = 1'b1;
    tick(2);
    ser_clk = 1'b0;
    tick(2);
    if (record) q.push_back(d);
  endtask

  task automatic send(logic [2:0] p, logic [13:0] sf, int n);
    bit b[18];
    b[0] = p[0]; b[1] = p[1]; b[2] = p[2]; b[3] = 1'b0;
    for (int i = 0; i < 14; i++) b[4+i] = sf[13-i];
    q.delete();
    ser_en = 1'b1;
    tick(2);
    for (int i = 0; i < n; i++) pulse(i < 18 ? b[i] : 1'b0, 1'b1);
    ser_en = 1'b0;
    settle = 1'b1;
    tick(4);
    if (q.size() == 18) begin
      exp_port = {q[2], q[1], q[0]};
      for (int i = 0; i < 14; i++) exp_sf[13-i] = q[4+i];
    end
    settle = 1'b0;
  endtask

  task automatic expect_now(string tag, logic [14:0] d, logic [2:0] p);
    total++;
    if (div_word !== d || port_bits !== p) begin
      bad++;
      $display("FAIL %s act=%h/%b exp=%h/%b", tag, div_word, port_bits, d, p);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    expect_now("R1 reset", 15'h0, 3'b000);
    total++;
    if (pll_off !== 1'b1) begin bad++; $display("FAIL R1 pll_off act=%b exp=1", pll_off); end
    settle = 1'b0;

    // R2 R6 valid words
    send(3'b101, 14'h1234, 18);
    expect_now("R2 word1", 15'h1234, 3'b101);
    send(3'b010, 14'h2ACB, 18);
    expect_now("R2 word2", 15'h2ACB, 3'b010);

    // R3 wrong counts
    send(3'b111, 14'h0F0F, 17);
    expect_now("R3 seventeen", 15'h2ACB, 3'b010);
    send(3'b111, 14'h0F0F, 19);
    expect_now("R3 nineteen", 15'h2ACB, 3'b010);

    // R4 idle edges before a valid word
    for (int i = 0; i < 5; i++) pulse(1'b1, 1'b0);
    send(3'b110, 14'h0155, 18);
    expect_now("R4 idle edges", 15'h0155, 3'b110);

    // R5 overlong burst
    send(3'b001, 14'h3333, 50);
    expect_now("R5 burst50", 15'h0155, 3'b110);

    // R9 zero factor then all ones
    send(3'b000, 14'h0000, 18);
    expect_now("R9 zero", 15'h0000, 3'b000);
    total++;
    if (pll_off !== 1'b1) begin bad++; $display("FAIL R9 pll_off act=%b exp=1", pll_off); end
    send(3'b111, 14'h3FFF, 18);
    expect_now("R6 ones", 15'h3FFF, 3'b111);
    total++;
    if (pll_off !== 1'b0) begin bad++; $display("FAIL R9 pll_off act=%b exp=0", pll_off); end

    // R8 select sweep
    for (int s = 0; s < 4; s++) begin
      ref_sel = 2'(s);
      tick(3);
      total++;
      if (int'(ref_ratio) != ratio_of(ref_sel)) begin
        bad++; $display("FAIL R8 sel=%0d act=%0d exp=%0d", s, ref_ratio, ratio_of(ref_sel));
      end
    end

    // R7 fixed controls
    total++;
    if ({cp_high, div_test, cp_off, presc_on, drive_off} !== 5'b10010) begin
      bad++; $display("FAIL R7 act=%b exp=10010", {cp_high, div_test, cp_off, presc_on, drive_off});
    end

    // R10 outputs hold with link idle
    tick(20);
    expect_now("R10 idle hold", 15'h3FFF, 3'b111);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule